// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This unit watches a bank of already-synchronized general-purpose input pins and turns pin activity into interrupt events. Each pin carries two configuration bits from outside the block: a mode bit that picks edge or level sensing, and a polarity bit that picks which edge or which level counts. A per-pin sense-disable input suppresses events from pins whose input path is switched off.

Detected events latch into sticky status bits, packed 32 pins per word. A second bitmap of enable bits, with the same packing, decides which latched events are forwarded. The single interrupt request output is high whenever any pin has both its status bit and its enable bit set. Software reaches the status and enable words over a simple 32-bit register port. It clears a status bit by writing a one to it. Status bits latch even when their enable bit is clear. Enabling a pin later therefore raises the request at once for an event already latched.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset every status bit and every enable bit reads 0 and the request output is low.
- R2: With mode bit 0 and polarity bit 0, a 0-to-1 transition on a pin input sets that pin's status bit at the next clock edge. A 1-to-0 transition does not set it.
- R3: With mode bit 0 and polarity bit 1, a 1-to-0 transition sets the status bit. A 0-to-1 transition does not set it.
- R4: With mode bit 1 and polarity bit 0, the status bit is set on every cycle the pin input is 0. A write-one clear has no effect while the input stays 0, and it takes effect once the input is 1.
- R5: With mode bit 1 and polarity bit 1, the status bit is set on every cycle the pin input is 1.
- R6: Status word k sits at byte address 0x80+4k and enable word k at 0x90+4k, for k = 0..2. Pin p maps to word p/32, bit p%32. An enable word write stores its bits. Bits above the last pin, and every other address, read 0. Writes to other addresses change nothing.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: The request output is high exactly when some pin has both its status bit and its enable bit set.
- R9: Status bits latch whether or not the pin is enabled. Setting the enable bit later raises the request.
- R10: A pin whose sense-disable input is high never sets its status bit.
- R11: When an event and a write-one clear hit the same bit in the same cycle, the bit ends set.
- R12: No edge event is reported on the first clock after reset, when there is no earlier sample to compare with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 95 | Synchronized pin levels |
| trigLevel | input | 95 | Per-pin mode: 0 edge, 1 level |
| trigInvert | input | 95 | Per-pin polarity select |
| senseDis | input | 95 | Per-pin input sensing disable |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe for the current address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the current address (combinational) |
| irqReq | output | 1 | Aggregate interrupt request |

## Verification
The status latch and the software write-one clear can both act on the same bit in one cycle. Directed steps issue the clear exactly in the cycle a rising edge is sampled, and again during every cycle of a held active level. The bench judges that the bit reads back set in both cases, and that the same clear succeeds once the level has gone. The random phase mixes clears, enable writes and pin activity on the same words, and compares every word and the request against a cycle-by-cycle model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 4;

  // strobes from the register decode into the datapath
  typedef struct packed {
    logic             statWr;
    logic             enWr;
    logic [SEL_W-1:0] wordSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 95,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 'h80,
  parameter int EN_BASE   = 'h90
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] statusVec,
  input  logic [NUM_PINS-1:0] enableVec,
  output ctrlStrobes_t        strobes,
  output logic [WORD_W-1:0]   busRdData
);
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;
  localparam int SPAN      = 4 * NUM_WORDS;

  logic [PAD_W-1:0]  statusPad, enablePad;
  logic [ADDR_W-1:0] statOff, enOff;
  logic              statHit, enHit;
  logic [SEL_W-1:0]  statIdx, enIdx;

  assign statusPad = PAD_W'(statusVec);
  assign enablePad = PAD_W'(enableVec);
  assign statOff   = busAddr - ADDR_W'(STAT_BASE);
  assign enOff     = busAddr - ADDR_W'(EN_BASE);
  assign statHit   = (statOff < ADDR_W'(SPAN)) && (statOff[1:0] == 2'b00);
  assign enHit     = (enOff < ADDR_W'(SPAN)) && (enOff[1:0] == 2'b00);
  assign statIdx   = SEL_W'(statOff >> 2);
  assign enIdx     = SEL_W'(enOff >> 2);

  always_comb begin
    strobes   = '0;
    busRdData = '0;
    if (statHit) begin
      strobes.statWr  = busWrEn;
      strobes.wordSel = statIdx;
      busRdData       = statusPad[int'(statIdx)*WORD_W +: WORD_W];
    end else if (enHit) begin
      strobes.enWr    = busWrEn;
      strobes.wordSel = enIdx;
      busRdData       = enablePad[int'(enIdx)*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] trigLevel,
  input  logic [NUM_PINS-1:0] trigInvert,
  input  logic [NUM_PINS-1:0] senseDis,
  input  ctrlStrobes_t        strobes,
  input  logic [WORD_W-1:0]   wrData,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] enableVec,
  output logic                irqReq
);
  logic [NUM_PINS-1:0] prevIn, evtHit, clrMask, enMask, enData;
  logic                primed;

  // one sample of history; edges need it, so nothing fires until primed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= '0;
      primed <= 1'b0;
    end else begin
      prevIn <= pinIn;
      primed <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int W = p / WORD_W;
    localparam int B = p % WORD_W;
    logic edgeSeen, levelSeen, wordHit;
    assign edgeSeen  = primed & (trigInvert[p] ? (prevIn[p] & ~pinIn[p])
                                               : (~prevIn[p] & pinIn[p]));
    assign levelSeen = trigInvert[p] ? pinIn[p] : ~pinIn[p];
    assign evtHit[p] = ~senseDis[p] & (trigLevel[p] ? levelSeen : edgeSeen);
    assign wordHit   = (strobes.wordSel == SEL_W'(W));
    assign clrMask[p] = strobes.statWr & wordHit & wrData[B];
    assign enMask[p]  = strobes.enWr & wordHit;
    assign enData[p]  = wrData[B];
  end

  // set beats clear: the event term is ORed after the clear mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusVec <= '0;
      enableVec <= '0;
    end else begin
      statusVec <= (statusVec & ~clrMask) | evtHit;
      enableVec <= (enableVec & ~enMask) | (enData & enMask);
    end
  end

  assign irqReq = |(statusVec & enableVec);
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 95,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 'h80,
  parameter int EN_BASE   = 'h90
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] trigLevel,
  input  logic [NUM_PINS-1:0] trigInvert,
  input  logic [NUM_PINS-1:0] senseDis,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  output logic                irqReq
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] statusVec, enableVec;

  gpio_irq_ctrl #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
    .STAT_BASE(STAT_BASE), .EN_BASE(EN_BASE)
  ) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn),
    .statusVec(statusVec), .enableVec(enableVec),
    .strobes(strobes), .busRdData(busRdData)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .trigLevel(trigLevel),
    .trigInvert(trigInvert), .senseDis(senseDis), .strobes(strobes),
    .wrData(busWrData), .statusVec(statusVec), .enableVec(enableVec),
    .irqReq(irqReq)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_PINS  = 95,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 'h80,
  parameter int EN_BASE   = 'h90
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [31:0]         busWrData,
  input logic [NUM_PINS-1:0] senseDis,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] enableVec,
  input logic                irqReq
);
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (statusVec == '0 && enableVec == '0 && !irqReq));

  a_r8_no_pending_no_req: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & enableVec) == '0) |-> !irqReq);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int W = p / 32;
    localparam int B = p % 32;
    a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusVec[p]) |->
        $past(busWrEn && busAddr == ADDR_W'(STAT_BASE + 4*W) && busWrData[B]));
    a_r10_disabled_no_set: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusVec[p]) |-> !$past(senseDis[p]));
    a_r6_enable_by_write: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(enableVec[p]) |->
        $past(busWrEn && busAddr == ADDR_W'(EN_BASE + 4*W)));
  end
endmodule

bind gpio_irq_top gpio_irq_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
  .STAT_BASE(STAT_BASE), .EN_BASE(EN_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .senseDis(senseDis), .statusVec(statusVec),
  .enableVec(enableVec), .irqReq(irqReq)
);

// File: tb/gpio_irq_top_tb_top.sv
module gpio_irq_top_tb_top;
  localparam int CLK_PERIOD = 40;
  localparam int NP = 95;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0, trigLevel = '0, trigInvert = '0, senseDis = '0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          irqReq;

  int nChecks = 0, nFails = 0;
  logic [NP-1:0] pinsV = '0, lvlV = '0, invV = '0, disV = '0;
  logic [NP-1:0] mStat = '0, mEn = '0, mPrev = '0;
  bit mPrimed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_top dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .trigLevel(trigLevel),
    .trigInvert(trigInvert), .senseDis(senseDis), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq)
  );

  function automatic logic [NP-1:0] expEvt();
    logic [NP-1:0] e = '0;
    for (int p = 0; p < NP; p++) begin
      if (disV[p]) e[p] = 0;
      else if (lvlV[p]) e[p] = invV[p] ? pinsV[p] : !pinsV[p];
      else if (!mPrimed) e[p] = 0;
      else e[p] = invV[p] ? (mPrev[p] && !pinsV[p]) : (!mPrev[p] && pinsV[p]);
    end
    return e;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [95:0] pad;
    int ia = int'(a);
    if (ia >= 'h80 && ia < 'h8C && ia % 4 == 0) begin
      pad = {1'b0, mStat};
      return pad[((ia - 'h80) / 4) * 32 +: 32];
    end
    if (ia >= 'h90 && ia < 'h9C && ia % 4 == 0) begin
      pad = {1'b0, mEn};
      return pad[((ia - 'h90) / 4) * 32 +: 32];
    end
    return '0;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; reads are combinational
  task automatic checkAll(input string tag);
    logic [7:0] addrs [7] = '{8'h80, 8'h84, 8'h88, 8'h90, 8'h94, 8'h98, 8'hA0};
    busWrEn = 1'b0;
    foreach (addrs[i]) begin
      busAddr = addrs[i];
      #1;
      check32({tag, $sformatf(" read %h", addrs[i])}, busRdData, expRead(addrs[i]));
    end
    check32({tag, " irq"}, {31'b0, irqReq}, {31'b0, |(mStat & mEn)});
  endtask

  // drive one cycle of stimulus from just after a falling edge
  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d);
    logic [NP-1:0] ev;
    pinIn = pinsV; trigLevel = lvlV; trigInvert = invV; senseDis = disV;
    busWrEn = wr; busAddr = a; busWrData = d;
    ev = expEvt();
    for (int p = 0; p < NP; p++) begin
      if (wr && int'(a) == 'h80 + 4*(p/32) && d[p%32]) mStat[p] = 1'b0;
      if (wr && int'(a) == 'h90 + 4*(p/32)) mEn[p] = d[p%32];
    end
    mStat = mStat | ev;
    mPrev = pinsV;
    mPrimed = 1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    pinsV[5] = 1'b1;
    pinIn = pinsV;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");

    step(0, 8'h00, 0);                 checkAll("R12 no edge after reset");

    pinsV[3] = 1; step(0, 8'h00, 0);   checkAll("R2 rising sets");
    pinsV[3] = 0; step(0, 8'h00, 0);   checkAll("R2 falling ignored");
    step(1, 8'h80, 32'h0);             checkAll("R7 write 0 keeps");
    step(1, 8'h80, 32'h8);             checkAll("R7 write 1 clears");

    invV[40] = 1; pinsV[40] = 1; step(0, 8'h00, 0); checkAll("R3 rising ignored");
    pinsV[40] = 0; step(0, 8'h00, 0);  checkAll("R3 falling sets");
    step(1, 8'h94, 32'h100);           checkAll("R9 late enable raises irq R8");

    lvlV[94] = 1; step(0, 8'h00, 0);   checkAll("R4 low level sets");
    step(1, 8'h88, 32'h4000_0000);     checkAll("R4 clear blocked while low");
    pinsV[94] = 1; step(1, 8'h88, 32'h4000_0000); checkAll("R4 clear after level gone");

    lvlV[64] = 1; invV[64] = 1; pinsV[64] = 1; step(0, 8'h00, 0); checkAll("R5 high level sets");
    pinsV[64] = 0; step(1, 8'h88, 32'h1); checkAll("R5 clear after level gone");

    disV[10] = 1; pinsV[10] = 1; step(0, 8'h00, 0); checkAll("R10 sensing disabled");

    pinsV[7] = 1; step(1, 8'h80, 32'h80); checkAll("R11 set wins over clear");

    step(1, 8'h98, 32'hFFFF_FFFF);     checkAll("R6 pad bits read 0");
    step(1, 8'hA0, 32'hFFFF_FFFF);     checkAll("R6 unmapped write ignored");
    step(1, 8'h90, 32'hFFFF_FFFF);     checkAll("R8 enable all");

    for (int n = 0; n < 400; n++) begin
      logic [7:0] ra;
      logic [2:0] sel;
      if (n % 40 == 0) begin
        lvlV = NP'({$urandom, $urandom, $urandom});
        invV = NP'({$urandom, $urandom, $urandom});
        disV = NP'({$urandom, $urandom, $urandom}) & NP'({$urandom, $urandom, $urandom});
      end
      pinsV = NP'({$urandom, $urandom, $urandom});
      sel = 3'($urandom % 7);
      case (sel)
        3'd0: ra = 8'h80; 3'd1: ra = 8'h84; 3'd2: ra = 8'h88;
        3'd3: ra = 8'h90; 3'd4: ra = 8'h94; 3'd5: ra = 8'h98;
        default: ra = 8'hA0;
      endcase
      step(($urandom % 2) == 1, ra, $urandom);
      checkAll("R8 random R11 R7");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule